// File: doc/BRIEF.md
# Manchester Line Encoder with Bit-Clock Divider

This block turns a serial NRZ transmit stream into a Manchester-coded line signal for a 10 Mb/s link. Its only clock is an oscillator at twice the bit rate, so 20 MHz gives 10 MHz. The block divides that clock by two into a symmetric bit clock and drives it out to the host controller. The host presents one data bit and a frame-enable flag per bit clock. Both are captured where the bit clock rises.

Each captured bit fills one bit cell on the line, one bit time after capture. The cell is two half-cells of opposite level. A one starts negative and a zero starts positive. Once a cell has begun, it always runs to its end.

Between frames the line idles in one of two modes, picked by a select input. In the first mode the line is held driven positive. In the second mode the line is released to zero differential, which is shown by the drive-enable output dropping. An active-low transmitting flag is held low for as long as cells are being sent.

Top module: `manchester_tx_enc`

## Requirements
- R1: `bit_clk` toggles on every `clk2x` rising edge, so it is high for one `clk2x` period and low for the next, and it reads 0 right after reset.
- R2: `tx_data` and `tx_en` are captured only at the `clk2x` edge where `bit_clk` goes from 0 to 1. Values they hold at any other edge have no effect on the line.
- R3: A bit captured at a rising edge of `bit_clk` appears on the line from the next rising edge of `bit_clk` onward. That is one bit time, or two `clk2x` cycles, after capture.
- R4: A captured one with enable high gives `line_pos`=0 (negative) for the first `clk2x` cycle of its cell and `line_pos`=1 (positive) for the second.
- R5: A captured zero with enable high gives `line_pos`=1 for the first half of its cell and `line_pos`=0 for the second.
- R6: A cell that has started always completes both halves. A capture with enable low returns the line to idle at the next cell boundary and starts no cell.
- R7: While idle with `idle_zero_sel`=0, the outputs are `drive_en`=1 and `line_pos`=1 (driven positive).
- R8: While idle with `idle_zero_sel`=1, the outputs are `drive_en`=0 (zero differential) and `line_pos`=1. While idle, a change of the select shows on `drive_en` after one `clk2x` edge. While cells are being sent, `drive_en` stays 1 whatever the select is.
- R9: `busy_n` is 0 during every cycle in which a cell is on the line, and 1 whenever the line is idle.
- R10: Synchronous active-high `rst` makes the next `clk2x` edge set `bit_clk`=0, put the line into the selected idle state with `busy_n`=1, and discard any captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Oscillator clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 1 | Serial NRZ data bit |
| tx_en | input | 1 | Frame enable, high while bits are valid |
| idle_zero_sel | input | 1 | Idle mode: 0 driven positive, 1 zero differential |
| bit_clk | output | 1 | Symmetric bit-rate clock (clk2x divided by two) |
| line_pos | output | 1 | Line polarity: 1 positive, 0 negative |
| drive_en | output | 1 | Line driver enable; 0 means zero differential |
| busy_n | output | 1 | Low while cells are being transmitted |

## Verification
A wrong divider phase would move captures to the falling edge of `bit_clk`. Every frame would then come out half a bit late, and this shows within two `clk2x` cycles of the first enabled bit. A corrupt capture register or encoder state would produce a half-cell with the wrong level, a missing mid-cell transition, or a `busy_n`/`drive_en` value that does not match. Each of these is visible in the very next half-cell. The bench therefore checks every half-cell of each frame against its own bit-time schedule. It also checks the idle state in the cycle right after a frame ends.

// File: rtl/mte_pkg.sv
package mte_pkg;

  // Line level encoding used on line_pos
  localparam logic LVL_POS = 1'b1;
  localparam logic LVL_NEG = 1'b0;

  // One captured bit-time sample
  typedef struct packed {
    logic en;
    logic d;
  } mte_sample_t;

  // Level of the first half-cell: a one leads negative
  function automatic logic lead_level(input logic d);
    return d ? LVL_NEG : LVL_POS;
  endfunction

  // Level of the second half-cell: a one trails positive
  function automatic logic trail_level(input logic d);
    return d ? LVL_POS : LVL_NEG;
  endfunction

endpackage

// File: rtl/mte_clkdiv.sv
module mte_clkdiv (
  input  logic clk2x,
  input  logic rst,
  output logic bit_clk,
  output logic cell_start
);

  logic phase_q;

  always_ff @(posedge clk2x) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign bit_clk    = phase_q;
  // The coming edge is a bit_clk rising edge
  assign cell_start = ~phase_q;

  AST_BITCLK_TOGGLE: assert property (@(posedge clk2x) disable iff (rst)
    1'b1 |=> (bit_clk != $past(bit_clk)));  // R1

endmodule

// File: rtl/mte_sampler.sv
module mte_sampler
  import mte_pkg::*;
(
  input  logic        clk2x,
  input  logic        rst,
  input  logic        cell_start,
  input  logic        tx_data,
  input  logic        tx_en,
  output mte_sample_t smp
);

  always_ff @(posedge clk2x) begin
    if (rst)             smp <= '0;
    else if (cell_start) smp <= '{en: tx_en, d: tx_data};
  end

  AST_SAMPLE_HOLD: assert property (@(posedge clk2x) disable iff (rst)
    !cell_start |=> $stable(smp));  // R2

endmodule

// File: rtl/mte_encoder.sv
module mte_encoder
  import mte_pkg::*;
(
  input  logic        clk2x,
  input  logic        rst,
  input  logic        cell_start,
  input  mte_sample_t smp,
  input  logic        idle_zero_sel,
  output logic        line_pos,
  output logic        drive_en,
  output logic        busy_n
);

  logic active_q;
  logic bit_q;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      active_q <= 1'b0;
      bit_q    <= 1'b0;
      line_pos <= LVL_POS;
      drive_en <= ~idle_zero_sel;
      busy_n   <= 1'b1;
    end else if (cell_start) begin
      if (smp.en) begin
        active_q <= 1'b1;
        bit_q    <= smp.d;
        line_pos <= lead_level(smp.d);
        drive_en <= 1'b1;
        busy_n   <= 1'b0;
      end else begin
        active_q <= 1'b0;
        line_pos <= LVL_POS;
        drive_en <= ~idle_zero_sel;
        busy_n   <= 1'b1;
      end
    end else begin
      if (active_q) begin
        line_pos <= trail_level(bit_q);
      end else begin
        line_pos <= LVL_POS;
        drive_en <= ~idle_zero_sel;
      end
    end
  end

  AST_MID_CELL_FLIP: assert property (@(posedge clk2x) disable iff (rst)
    (!cell_start && active_q) |=> (line_pos != $past(line_pos)));  // R4

  AST_IDLE_POSITIVE: assert property (@(posedge clk2x) disable iff (rst)
    busy_n |-> (line_pos == LVL_POS));  // R7

  AST_IDLE_SELECT: assert property (@(posedge clk2x) disable iff (rst)
    busy_n |-> (drive_en == !$past(idle_zero_sel)));  // R8

  AST_BUSY_DRIVES: assert property (@(posedge clk2x) disable iff (rst)
    !busy_n |-> drive_en);  // R9

endmodule

// File: rtl/manchester_tx_enc.sv
module manchester_tx_enc
  import mte_pkg::*;
(
  input  logic clk2x,
  input  logic rst,
  input  logic tx_data,
  input  logic tx_en,
  input  logic idle_zero_sel,
  output logic bit_clk,
  output logic line_pos,
  output logic drive_en,
  output logic busy_n
);

  logic        cell_start;
  mte_sample_t smp;

  mte_clkdiv u_div (
    .clk2x      (clk2x),
    .rst        (rst),
    .bit_clk    (bit_clk),
    .cell_start (cell_start)
  );

  mte_sampler u_smp (
    .clk2x      (clk2x),
    .rst        (rst),
    .cell_start (cell_start),
    .tx_data    (tx_data),
    .tx_en      (tx_en),
    .smp        (smp)
  );

  mte_encoder u_enc (
    .clk2x         (clk2x),
    .rst           (rst),
    .cell_start    (cell_start),
    .smp           (smp),
    .idle_zero_sel (idle_zero_sel),
    .line_pos      (line_pos),
    .drive_en      (drive_en),
    .busy_n        (busy_n)
  );

  AST_RESET_IDLE: assert property (@(posedge clk2x)
    $past(rst) |-> (busy_n && !bit_clk));  // R10

endmodule

// File: tb/manchester_tx_enc_test.sv
module manchester_tx_enc_test;

  logic clk2x = 1'b0;
  logic rst   = 1'b1;
  logic tx_data = 1'b0;
  logic tx_en   = 1'b0;
  logic idle_zero_sel = 1'b0;
  logic bit_clk, line_pos, drive_en, busy_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk2x = ~clk2x;

  manchester_tx_enc uut (
    .clk2x(clk2x), .rst(rst), .tx_data(tx_data), .tx_en(tx_en),
    .idle_zero_sel(idle_zero_sel), .bit_clk(bit_clk), .line_pos(line_pos),
    .drive_en(drive_en), .busy_n(busy_n)
  );

  task automatic tick();
    @(negedge clk2x);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  // Reach a negedge whose following posedge is a bit_clk rising edge
  task automatic align();
    while (bit_clk !== 1'b0) tick();
  endtask

  task automatic test_reset_state();
    rst = 1'b1;
    repeat (3) tick();
    chk("R10", "bit_clk after reset", bit_clk, 1'b0);
    chk("R10", "busy_n after reset", busy_n, 1'b1);
    chk("R10", "line_pos after reset", line_pos, 1'b1);
    chk("R7", "drive_en after reset", drive_en, 1'b1);
    rst = 1'b0;
  endtask

  task automatic test_clock();
    logic prev;
    align();
    prev = bit_clk;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R1", "bit_clk toggles each clk2x", bit_clk, ~prev);
      prev = bit_clk;
    end
  endtask

  task automatic run_frame(input string name, input logic [15:0] bits, input int n, input logic sel);
    idle_zero_sel = sel;
    align();
    for (int k = 0; k <= n + 1; k++) begin
      if (k < n) begin tx_en = 1'b1; tx_data = bits[k]; end
      else       begin tx_en = 1'b0; tx_data = 1'b0; end
      if (k >= 2) begin
        chk(bits[k-2] ? "R4" : "R5", {name, " second half"}, line_pos, bits[k-2]);
        chk("R9", {name, " busy in second half"}, busy_n, 1'b0);
        chk("R8", {name, " drive in cell"}, drive_en, 1'b1);
      end
      tick();
      if (k == 0) begin
        chk("R3", {name, " no cell before one bit lag"}, busy_n, 1'b1);
      end else if (k - 1 < n) begin
        chk(bits[k-1] ? "R4" : "R5", {name, " first half"}, line_pos, ~bits[k-1]);
        chk("R9", {name, " busy in first half"}, busy_n, 1'b0);
      end else begin
        chk("R6", {name, " idle after frame"}, busy_n, 1'b1);
        chk(sel ? "R8" : "R7", {name, " idle drive"}, drive_en, ~sel);
        chk("R7", {name, " idle level"}, line_pos, 1'b1);
      end
      tick();
    end
  endtask

  task automatic test_off_edge_ignored();
    idle_zero_sel = 1'b0;
    align();
    tx_en = 1'b1; tx_data = 1'b1;
    tick();
    tx_en = 1'b0; tx_data = 1'b0;   // off-edge change
    tick(); tick();
    chk("R2", "off-edge change kept one first half", line_pos, 1'b0);
    chk("R6", "cell runs after enable drop", busy_n, 1'b0);
    tick();
    chk("R6", "second half completes", line_pos, 1'b1);
    tick();
    chk("R6", "idle after single cell", busy_n, 1'b1);
    align();
    tx_en = 1'b0;
    tick();
    tx_en = 1'b1; tx_data = 1'b0;   // off-edge pulse only
    tick();
    tx_en = 1'b0;
    tick();
    chk("R2", "off-edge enable pulse ignored a", busy_n, 1'b1);
    tick();
    chk("R2", "off-edge enable pulse ignored b", busy_n, 1'b1);
  endtask

  task automatic test_select_behaviour();
    idle_zero_sel = 1'b0;
    align();
    tx_en = 1'b1; tx_data = 1'b0;
    tick();
    idle_zero_sel = 1'b1;
    tick();
    tx_en = 1'b0;
    tick();
    chk("R8", "drive held in cell first half", drive_en, 1'b1);
    chk("R5", "zero leads positive", line_pos, 1'b1);
    tick();
    chk("R8", "drive held in cell second half", drive_en, 1'b1);
    chk("R5", "zero trails negative", line_pos, 1'b0);
    tick();
    chk("R8", "zero differential idle", drive_en, 1'b0);
    idle_zero_sel = 1'b0;
    tick();
    chk("R8", "select follows in idle to 0", drive_en, 1'b1);
    idle_zero_sel = 1'b1;
    tick();
    chk("R8", "select follows in idle to 1", drive_en, 1'b0);
    idle_zero_sel = 1'b0;
    tick();
  endtask

  task automatic test_reset_mid_frame();
    idle_zero_sel = 1'b1;
    align();
    tx_en = 1'b1; tx_data = 1'b1;
    tick(); tick();
    rst = 1'b1;
    tick();
    chk("R10", "bit_clk zero on reset", bit_clk, 1'b0);
    chk("R10", "busy released on reset", busy_n, 1'b1);
    chk("R10", "idle drive on reset", drive_en, 1'b0);
    chk("R10", "idle level on reset", line_pos, 1'b1);
    rst = 1'b0; tx_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10", "pending bit discarded", busy_n, 1'b1);
    end
    idle_zero_sel = 1'b0;
    tick();
  endtask

  initial begin
    test_reset_state();
    test_clock();
    run_frame("mixed", 16'b0100_1101, 8, 1'b0);
    run_frame("ones", 16'hFFFF, 6, 1'b0);
    run_frame("zeros", 16'h0000, 6, 1'b1);
    run_frame("alt", 16'b1010_1010_0101, 12, 1'b1);
    test_off_edge_ignored();
    test_select_behaviour();
    test_reset_mid_frame();
    run_frame("after_reset", 16'b0110, 4, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk2x);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule